// File: doc/BRIEF.md
# Reserved-Opcode Trap Entry and Return Controller

This block sits beside the execute stage of a small 32-bit processor whose instructions are 16 or 32 bits wide and may start on any halfword. Each cycle it looks at the opcode field of the instruction presented for execution. It compares that opcode against a parameterised table of implemented opcodes. When the opcode is not implemented, the block blocks the instruction from taking effect and takes a trap. Taking a trap means four things: the block saves the mode, interrupt-enable and carry bits of the status word into backup copies, clears interrupt-enable and carry, records the exact halfword address of the faulting instruction, and steers fetch to a fixed handler vector on the following cycle.

The block also carries out the return from the handler. When the return instruction is signalled, the status bits are reloaded from their backup copies and fetch is steered back to the recorded address with its two low bits cleared. A fault in the second halfword of a word therefore resumes at the start of that word. The block keeps a small status port so that ordinary instructions can write the three status bits. It also decides whether a pending external interrupt may be accepted in the current cycle.

Top module: `rsvd_trap_ctrl`

## Requirements
- R1: `trap_take` is high in the same cycle when `ins_valid` is high and bit `ins_opcode` of parameter `IMPL_MASK` is 0. With the default mask, opcodes 10 and 15 are reserved and every other opcode is implemented. When `ins_valid` is low, no trap is taken.
- R2: During a trap, `exec_en` is low and a status write offered through `psw_we`/`psw_wdata` in that cycle is discarded.
- R3: `irq_take` is high only when `ext_irq_req`, interrupt-enable and a valid implemented instruction are all present. In a cycle that takes a trap, `irq_take` is low and the interrupt stays pending.
- R4: In the cycle after a trap, `bak_sm`, `bak_ie` and `bak_c` hold the values that `psw_sm`, `psw_ie` and `psw_c` had in the trap cycle.
- R5: In the cycle after a trap, `psw_sm` is unchanged and `psw_ie` and `psw_c` are 0.
- R6: In the cycle after a trap, `bpc` equals `ins_addr` of the faulting instruction, and that includes bit 1. Bit 1 is 0 for a word-aligned fault and 1 for a fault in the second halfword.
- R7: In the cycle after a trap, `redir_valid` is 1 and `redir_pc` equals parameter `VECTOR` (default 0x80). When no trap and no return is taken, `redir_valid` is 0.
- R8: In the cycle after `ret_req` is taken (it is taken only when no trap occurs in the same cycle), `redir_valid` is 1 and `redir_pc` equals `bpc` with bits 1:0 cleared.
- R9: A taken return reloads `psw_sm`, `psw_ie` and `psw_c` from `bak_sm`, `bak_ie` and `bak_c` by the next cycle.
- R10: A valid implemented instruction drives `exec_en` high. When `psw_we` is high, `psw_wdata` (bit 2 = mode, bit 1 = interrupt-enable, bit 0 = carry) appears on the status outputs in the next cycle, and no redirect occurs.
- R11: After reset, all status, backup and `bpc` outputs are 0 and `redir_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | An instruction is presented for execution |
| ins_opcode | input | OPC_W | Opcode field of that instruction |
| ins_addr | input | ADDR_W | Halfword address of that instruction |
| ext_irq_req | input | 1 | External interrupt request level |
| ret_req | input | 1 | Return-from-handler instruction is executing |
| psw_we | input | 1 | Instruction wants to write the status bits |
| psw_wdata | input | 3 | New status bits {mode, int-enable, carry} |
| trap_take | output | 1 | Reserved opcode detected, trap taken this cycle |
| exec_en | output | 1 | Instruction may commit its results |
| irq_take | output | 1 | External interrupt accepted this cycle |
| redir_valid | output | 1 | Fetch redirect this cycle |
| redir_pc | output | ADDR_W | Redirect target address |
| psw_sm | output | 1 | Current mode bit |
| psw_ie | output | 1 | Current interrupt-enable bit |
| psw_c | output | 1 | Current carry bit |
| bak_sm | output | 1 | Saved mode bit |
| bak_ie | output | 1 | Saved interrupt-enable bit |
| bak_c | output | 1 | Saved carry bit |
| bpc | output | ADDR_W | Saved faulting-instruction address |

## Verification
Three outputs, `trap_take`, `exec_en` and `irq_take`, are combinational. The bench samples them one time unit after driving inputs on the falling edge, before the next rising edge. Everything else is registered and is due exactly one rising edge after the triggering cycle. This covers the saved and updated status bits, `bpc`, and the redirect pulse. The bench reads these at the following falling edge, while the single-cycle `redir_valid` pulse is still present. Idle cycles between scenarios show that the redirect pulse lasts one cycle and that registered state holds.

// File: rtl/rsvd_trap_pkg.sv
// Package: shared types for the reserved-opcode trap controller.
// Assumes a three-bit status group {mode, interrupt-enable, carry}.
package rsvd_trap_pkg;
    typedef struct packed {
        logic sm;
        logic ie;
        logic c;
    } psw_bits_t;
endpackage

// File: rtl/rsvd_opc_decode.sv
// Module: rsvd_opc_decode
// Flags an opcode that has no implementation. IMPL_MASK bit i = 1 means
// opcode i exists. The output is qualified by the valid strobe.
// Assumes 2**OPC_W is small (one comparator per code).
module rsvd_opc_decode #(
    parameter int unsigned OPC_W = 4,
    parameter logic [(1<<OPC_W)-1:0] IMPL_MASK = '1
) (
    input  logic             valid,
    input  logic [OPC_W-1:0] opcode,
    output logic             rsv_hit
);
    localparam int unsigned NUM_OPC = 1 << OPC_W;

    logic [NUM_OPC-1:0] match;

    // One comparator per unimplemented code.
    for (genvar g = 0; g < NUM_OPC; g++) begin : g_code
        assign match[g] = (opcode == OPC_W'(g)) & ~IMPL_MASK[g];
    end

    // Any unimplemented match on a valid instruction is a reserved opcode.
    assign rsv_hit = valid & (|match);
endmodule

// File: rtl/rsvd_psw_bank.sv
// Module: rsvd_psw_bank
// Holds the live status bits, their backup copies and the backup PC.
// Priority: trap entry > return > ordinary write. Assumes the caller has
// already made the take signals mutually exclusive.
module rsvd_psw_bank
    import rsvd_trap_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_take,
    input  logic              ret_take,
    input  logic              wr_take,
    input  psw_bits_t         wr_val,
    input  logic [ADDR_W-1:0] fault_addr,
    output psw_bits_t         psw,
    output psw_bits_t         bak,
    output logic [ADDR_W-1:0] bpc
);
    // Status and backup bits: save/clear on entry, restore on return, else write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psw <= '0;
            bak <= '0;
        end else if (trap_take) begin
            bak    <= psw;
            psw.ie <= 1'b0;
            psw.c  <= 1'b0;
        end else if (ret_take) begin
            psw <= bak;
        end else if (wr_take) begin
            psw <= wr_val;
        end
    end

    // Backup PC: records the exact halfword address of the faulting instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bpc <= '0;
        end else if (trap_take) begin
            bpc <= fault_addr;
        end
    end
endmodule

// File: rtl/rsvd_redirect.sv
// Module: rsvd_redirect
// Produces a one-cycle fetch redirect: the handler vector after a trap, or
// the word-aligned backup PC after a return. Assumes VECTOR is word aligned.
module rsvd_redirect #(
    parameter int unsigned ADDR_W = 32,
    parameter logic [ADDR_W-1:0] VECTOR = 'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_take,
    input  logic              ret_take,
    input  logic [ADDR_W-1:0] bpc,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_pc
);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

    // Register the redirect pulse and its target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_pc    <= '0;
        end else begin
            redir_valid <= trap_take | ret_take;
            if (trap_take) begin
                redir_pc <= VECTOR;
            end else if (ret_take) begin
                redir_pc <= bpc & WORD_MASK;
            end
        end
    end
endmodule

// File: rtl/rsvd_trap_ctrl.sv
// Module: rsvd_trap_ctrl (top)
// Detects reserved opcodes, blocks the faulting instruction, arbitrates it
// against an external interrupt, and runs trap entry and return.
// Assumes ret_req is already decoded and that the interrupt entry sequence
// itself lives elsewhere (only the accept strobe is produced here).
module rsvd_trap_ctrl
    import rsvd_trap_pkg::*;
#(
    parameter int unsigned OPC_W = 4,
    parameter int unsigned ADDR_W = 32,
    parameter logic [(1<<OPC_W)-1:0] IMPL_MASK = 16'h7BFF,
    parameter logic [ADDR_W-1:0] VECTOR = 'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [OPC_W-1:0]  ins_opcode,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              ext_irq_req,
    input  logic              ret_req,
    input  logic              psw_we,
    input  logic [2:0]        psw_wdata,
    output logic              trap_take,
    output logic              exec_en,
    output logic              irq_take,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_pc,
    output logic              psw_sm,
    output logic              psw_ie,
    output logic              psw_c,
    output logic              bak_sm,
    output logic              bak_ie,
    output logic              bak_c,
    output logic [ADDR_W-1:0] bpc
);
    logic      rsv_hit;
    logic      ret_take;
    logic      wr_take;
    psw_bits_t psw;
    psw_bits_t bak;

    rsvd_opc_decode #(.OPC_W(OPC_W), .IMPL_MASK(IMPL_MASK)) u_dec (
        .valid   (ins_valid),
        .opcode  (ins_opcode),
        .rsv_hit (rsv_hit)
    );

    // Arbitration: the trap beats return, status write and interrupt accept.
    always_comb begin
        trap_take = rsv_hit;
        exec_en   = ins_valid & ~rsv_hit;
        ret_take  = ret_req & ~rsv_hit;
        wr_take   = psw_we & ins_valid & ~rsv_hit & ~ret_req;
        irq_take  = ext_irq_req & psw.ie & ins_valid & ~rsv_hit;
    end

    rsvd_psw_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_take  (trap_take),
        .ret_take   (ret_take),
        .wr_take    (wr_take),
        .wr_val     (psw_bits_t'(psw_wdata)),
        .fault_addr (ins_addr),
        .psw        (psw),
        .bak        (bak),
        .bpc        (bpc)
    );

    rsvd_redirect #(.ADDR_W(ADDR_W), .VECTOR(VECTOR)) u_redir (
        .clk         (clk),
        .rst_n       (rst_n),
        .trap_take   (trap_take),
        .ret_take    (ret_take),
        .bpc         (bpc),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc)
    );

    // Expose the status groups as flat bits.
    assign psw_sm = psw.sm;
    assign psw_ie = psw.ie;
    assign psw_c  = psw.c;
    assign bak_sm = bak.sm;
    assign bak_ie = bak.ie;
    assign bak_c  = bak.c;
endmodule

// File: rtl/rsvd_trap_ctrl_chk.sv
// Module: rsvd_trap_ctrl_chk
// Temporal checks on the top module's ports, attached by bind below.
module rsvd_trap_ctrl_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter logic [ADDR_W-1:0] VECTOR = 'h80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trap_take,
    input logic              exec_en,
    input logic              irq_take,
    input logic              ret_req,
    input logic              ins_valid,
    input logic [ADDR_W-1:0] ins_addr,
    input logic              redir_valid,
    input logic [ADDR_W-1:0] redir_pc,
    input logic              psw_sm,
    input logic              psw_ie,
    input logic              psw_c,
    input logic              bak_sm,
    input logic              bak_ie,
    input logic              bak_c,
    input logic [ADDR_W-1:0] bpc
);
    AST_TRAP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |-> ins_valid);  // R1
    AST_TRAP_BLOCKS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |-> !exec_en);  // R2
    AST_IRQ_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |-> !irq_take);  // R3
    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> psw_ie);  // R3
    AST_BACKUP_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (bak_sm == $past(psw_sm)) && (bak_ie == $past(psw_ie)) && (bak_c == $past(psw_c)));  // R4
    AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> !psw_ie && !psw_c && (psw_sm == $past(psw_sm)));  // R5
    AST_BPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (bpc == $past(ins_addr)));  // R6
    AST_VECTOR_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> redir_valid && (redir_pc == VECTOR));  // R7
    AST_RETURN_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !trap_take) |=> redir_valid && (redir_pc[1:0] == 2'b00)
            && (redir_pc[ADDR_W-1:2] == $past(bpc[ADDR_W-1:2])));  // R8
    AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !trap_take) |=> (psw_sm == $past(bak_sm)) && (psw_ie == $past(bak_ie)) && (psw_c == $past(bak_c)));  // R9
    AST_NO_STRAY_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_take && !ret_req) |=> !redir_valid);  // R7
endmodule

bind rsvd_trap_ctrl rsvd_trap_ctrl_chk #(.ADDR_W(ADDR_W), .VECTOR(VECTOR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trap_take   (trap_take),
    .exec_en     (exec_en),
    .irq_take    (irq_take),
    .ret_req     (ret_req),
    .ins_valid   (ins_valid),
    .ins_addr    (ins_addr),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .psw_sm      (psw_sm),
    .psw_ie      (psw_ie),
    .psw_c       (psw_c),
    .bak_sm      (bak_sm),
    .bak_ie      (bak_ie),
    .bak_c       (bak_c),
    .bpc         (bpc)
);

// File: tb/test_rsvd_trap_ctrl.sv
// Directed bench for rsvd_trap_ctrl: one task per scenario.
module test_rsvd_trap_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] VEC = 32'h80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [3:0]  ins_opcode = '0;
    logic [31:0] ins_addr = '0;
    logic        ext_irq_req = 1'b0;
    logic        ret_req = 1'b0;
    logic        psw_we = 1'b0;
    logic [2:0]  psw_wdata = '0;
    logic        trap_take, exec_en, irq_take, redir_valid;
    logic [31:0] redir_pc, bpc;
    logic        psw_sm, psw_ie, psw_c, bak_sm, bak_ie, bak_c;

    int checks = 0;
    int errors = 0;

    rsvd_trap_ctrl i_rsvd_trap_ctrl (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_opcode(ins_opcode),
        .ins_addr(ins_addr), .ext_irq_req(ext_irq_req), .ret_req(ret_req),
        .psw_we(psw_we), .psw_wdata(psw_wdata), .trap_take(trap_take),
        .exec_en(exec_en), .irq_take(irq_take), .redir_valid(redir_valid),
        .redir_pc(redir_pc), .psw_sm(psw_sm), .psw_ie(psw_ie), .psw_c(psw_c),
        .bak_sm(bak_sm), .bak_ie(bak_ie), .bak_c(bak_c), .bpc(bpc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance one rising edge and land on the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        ins_valid = 0; ins_opcode = 0; ins_addr = 0; ext_irq_req = 0;
        ret_req = 0; psw_we = 0; psw_wdata = 0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        idle_inputs();
        step(); step();
        rst_n = 1;
        chk("R11 psw after reset", {29'b0, psw_sm, psw_ie, psw_c}, 32'h0);
        chk("R11 backup after reset", {29'b0, bak_sm, bak_ie, bak_c}, 32'h0);
        chk("R11 bpc after reset", bpc, 32'h0);
        chk("R11 redir_valid after reset", {31'b0, redir_valid}, 32'h0);
    endtask

    // Write status bits through a valid implemented opcode (R10).
    task automatic t_write_psw(input logic [2:0] v);
        ins_valid = 1; ins_opcode = 4'd1; ins_addr = 32'h100; psw_we = 1; psw_wdata = v;
        #1;
        chk("R10 exec_en on implemented opcode", {31'b0, exec_en}, 32'h1);
        chk("R1 no trap on implemented opcode", {31'b0, trap_take}, 32'h0);
        step();
        idle_inputs();
        chk("R10 psw written", {29'b0, psw_sm, psw_ie, psw_c}, {29'b0, v});
        chk("R10 no redirect", {31'b0, redir_valid}, 32'h0);
    endtask

    // Reserved opcode at addr with status preset to pre; a zero write is offered too.
    task automatic t_trap(input logic [3:0] opc, input logic [31:0] addr, input logic [2:0] pre);
        t_write_psw(pre);
        ins_valid = 1; ins_opcode = opc; ins_addr = addr; psw_we = 1; psw_wdata = 3'b000;
        #1;
        chk("R1 trap_take on reserved opcode", {31'b0, trap_take}, 32'h1);
        chk("R2 exec_en blocked", {31'b0, exec_en}, 32'h0);
        step();
        idle_inputs();
        chk("R4 backup bits saved", {29'b0, bak_sm, bak_ie, bak_c}, {29'b0, pre});
        chk("R5 sm kept, ie/c cleared", {29'b0, psw_sm, psw_ie, psw_c}, {29'b0, pre[2], 2'b00});
        chk("R2 status write discarded", {31'b0, psw_sm}, {31'b0, pre[2]});
        chk("R6 bpc is faulting address", bpc, addr);
        chk("R6 bpc halfword bit", {31'b0, bpc[1]}, {31'b0, addr[1]});
        chk("R7 redirect valid", {31'b0, redir_valid}, 32'h1);
        chk("R7 redirect to vector", redir_pc, VEC);
        step();
        chk("R7 redirect is one pulse", {31'b0, redir_valid}, 32'h0);
    endtask

    // Return: expects word-aligned resume and restored status.
    task automatic t_return(input logic [31:0] exp_pc, input logic [2:0] exp_psw);
        ret_req = 1;
        step();
        idle_inputs();
        chk("R8 return redirect valid", {31'b0, redir_valid}, 32'h1);
        chk("R8 return address aligned", redir_pc, exp_pc);
        chk("R9 status restored", {29'b0, psw_sm, psw_ie, psw_c}, {29'b0, exp_psw});
        step();
    endtask

    task automatic t_invalid_slot();
        ins_valid = 0; ins_opcode = 4'd15; ins_addr = 32'h40;
        #1;
        chk("R1 no trap without valid", {31'b0, trap_take}, 32'h0);
        step();
        idle_inputs();
        chk("R7 no redirect without trap", {31'b0, redir_valid}, 32'h0);
    endtask

    task automatic t_irq_collide();
        t_write_psw(3'b010);
        ins_valid = 1; ins_opcode = 4'd10; ins_addr = 32'h206; ext_irq_req = 1;
        #1;
        chk("R3 trap wins over irq", {31'b0, trap_take}, 32'h1);
        chk("R3 irq not taken with trap", {31'b0, irq_take}, 32'h0);
        step();
        ins_valid = 1; ins_opcode = 4'd2; ins_addr = 32'h80;
        #1;
        chk("R3 irq stays pending with ie cleared", {31'b0, irq_take}, 32'h0);
        ins_valid = 0;
        step();
        ext_irq_req = 1;
        ret_req = 1;
        step();
        ret_req = 0;
        chk("R8 return from halfword fault", redir_pc, 32'h204);
        ins_valid = 1; ins_opcode = 4'd3; ins_addr = 32'h204;
        #1;
        chk("R3 pending irq taken after return", {31'b0, irq_take}, 32'h1);
        step();
        idle_inputs();
    endtask

    initial begin
        t_reset();
        t_write_psw(3'b101);
        t_invalid_slot();
        t_trap(4'd15, 32'h0000_0004, 3'b111);
        t_return(32'h0000_0004, 3'b111);
        t_trap(4'd10, 32'h0000_0006, 3'b111);
        t_return(32'h0000_0004, 3'b111);
        t_trap(4'd15, 32'h0000_1A32, 3'b001);
        t_return(32'h0000_1A30, 3'b001);
        t_irq_collide();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule